// File: doc/BRIEF.md
# Scaler Datapath Mode Selector

This block picks the operating mode of a video scaler datapath from the class of the incoming pixel format and the four scale ratios: luma horizontal, luma vertical, chroma horizontal and chroma vertical. Each ratio is an unsigned fixed-point number. A ratio exactly equal to one means that direction passes through without scaling. The decision follows a strict priority. A floating-point source on a fixed-format datapath skips the scaler entirely. When nothing needs scaling, the block selects full 4:4:4 bypass. Otherwise it selects a scaling mode that depends on the format. For 4:2:0 content, a plane with unity ratios is passed through while the other plane is scaled.

The block also sets the black-level offsets that go with the format. The luma/RGB offset is always zero. The chroma offset is mid-scale for video formats and zero for other formats. The mode and both offsets are registered. They change only on a cycle where the load strobe is high, so software or a sequencer can present new inputs and commit them in a single cycle.

Top module: `scl_mode_select`

## Requirements
- R1: During reset and after reset release, before any load, the mode output is 6 (scaler bypass) and both offsets are 0.
- R2: When fixed_fmt is 1 and fmt is 3 (FP16), a load gives mode 6. This holds whatever the ratios are and whatever always_scale is.
- R3: When the R2 condition is false, all four ratios equal one, and always_scale is 0, a load gives mode 0 for every format code.
- R4: Otherwise, for a format other than 2 (4:2:0), a load gives mode 2 when fmt is 1 (4:4:4 video) and mode 1 when fmt is 0 (RGB) or 3 (FP16 without the fixed flag).
- R5: Otherwise, for fmt 2, a load gives mode 4 (luma bypass) when both luma ratios equal one.
- R6: Otherwise, for fmt 2, a load gives mode 5 (chroma bypass) when both chroma ratios equal one and the luma ratios do not.
- R7: For fmt 2, when neither plane has both its ratios equal to one, a load gives mode 3.
- R8: When always_scale is 1 and all ratios are one, the R3 bypass is skipped and the mode follows R4 to R7.
- R9: On a load, offset_y becomes 0. offset_c becomes 16'h8000 when fmt is 1 or 2, and 0 when fmt is 0 or 3.
- R10: On a cycle where load is 0, mode, offset_y and offset_c keep their values whatever the other inputs do.
- R11: A ratio counts as one only when it equals exactly 1<<FRAC_W. A value one LSB above or below that counts as scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load | input | 1 | Commit strobe: capture the decision this cycle |
| fmt | input | 2 | Format class: 0 RGB, 1 4:4:4 video, 2 4:2:0 video, 3 FP16 |
| fixed_fmt | input | 1 | Datapath processes fixed-point data only |
| always_scale | input | 1 | Debug: never select full bypass |
| ratio_h_luma | input | RATIO_W | Luma horizontal ratio, FRAC_W fraction bits |
| ratio_v_luma | input | RATIO_W | Luma vertical ratio |
| ratio_h_chroma | input | RATIO_W | Chroma horizontal ratio |
| ratio_v_chroma | input | RATIO_W | Chroma vertical ratio |
| mode | output | 3 | Registered mode code 0..6 |
| offset_y | output | OFFSET_W | Registered luma/RGB black offset |
| offset_c | output | OFFSET_W | Registered chroma black offset |

## Verification
The bench builds the block with its defaults: 32-bit ratios with 19 fraction bits and 16-bit offsets. With these values, unity is 32'h0008_0000. Ratios one LSB on either side of unity, 1.5, and 0.5 can all be written directly. This places the exact-equality boundary of the unity test within reach, along with every branch of the priority chain. The chain is exercised for each format class, with and without the fixed flag and the debug flag.

// File: rtl/scl_mode_pkg.sv
`timescale 1ns/1ps
package scl_mode_pkg;

  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_VID444 = 2'd1,
    FMT_VID420 = 2'd2,
    FMT_FP16   = 2'd3
  } fmt_class_e;

  typedef enum logic [2:0] {
    MD_BYPASS_444  = 3'd0,
    MD_SCALE_RGB   = 3'd1,
    MD_SCALE_Y444  = 3'd2,
    MD_SCALE_Y420  = 3'd3,
    MD_420_LUMA_BP = 3'd4,
    MD_420_CHRM_BP = 3'd5,
    MD_SCL_BYPASS  = 3'd6
  } scl_mode_e;

  localparam int NUM_RATIOS = 4;
  localparam int IDX_H_LUMA = 0;
  localparam int IDX_V_LUMA = 1;
  localparam int IDX_H_CHRM = 2;
  localparam int IDX_V_CHRM = 3;

  function automatic logic fmt_is_video(input fmt_class_e f);
    return (f == FMT_VID444) || (f == FMT_VID420);
  endfunction

endpackage

// File: rtl/scl_rst_sync.sv
`timescale 1ns/1ps
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/scl_unity_detect.sv
`timescale 1ns/1ps
module scl_unity_detect #(
  parameter int RATIO_W = 32,
  parameter int FRAC_W  = 19
) (
  input  logic [RATIO_W-1:0] ratio,
  output logic               is_one
);
  localparam logic [RATIO_W-1:0] UNITY = RATIO_W'(1) << FRAC_W;

  assign is_one = (ratio == UNITY);
endmodule

// File: rtl/scl_mode_decide.sv
`timescale 1ns/1ps
module scl_mode_decide
  import scl_mode_pkg::*;
#(
  parameter int                OFFSET_W     = 16,
  parameter logic [OFFSET_W-1:0] CHROMA_MID = OFFSET_W'(16'h8000)
) (
  input  fmt_class_e            fmt,
  input  logic                  fixed_fmt,
  input  logic                  always_scale,
  input  logic [NUM_RATIOS-1:0] unity,
  output scl_mode_e             mode_sel,
  output logic [OFFSET_W-1:0]   off_y_sel,
  output logic [OFFSET_W-1:0]   off_c_sel
);
  logic luma_unity;
  logic chroma_unity;

  assign luma_unity   = unity[IDX_H_LUMA] & unity[IDX_V_LUMA];
  assign chroma_unity = unity[IDX_H_CHRM] & unity[IDX_V_CHRM];

  always_comb begin
    if (fixed_fmt && (fmt == FMT_FP16)) begin
      mode_sel = MD_SCL_BYPASS;
    end else if (luma_unity && chroma_unity && !always_scale) begin
      mode_sel = MD_BYPASS_444;
    end else if (fmt != FMT_VID420) begin
      mode_sel = (fmt == FMT_VID444) ? MD_SCALE_Y444 : MD_SCALE_RGB;
    end else if (luma_unity) begin
      mode_sel = MD_420_LUMA_BP;
    end else if (chroma_unity) begin
      mode_sel = MD_420_CHRM_BP;
    end else begin
      mode_sel = MD_SCALE_Y420;
    end
  end

  assign off_y_sel = '0;
  assign off_c_sel = fmt_is_video(fmt) ? CHROMA_MID : '0;
endmodule

// File: rtl/scl_mode_select.sv
`timescale 1ns/1ps
module scl_mode_select
  import scl_mode_pkg::*;
#(
  parameter int RATIO_W  = 32,
  parameter int FRAC_W   = 19,
  parameter int OFFSET_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [1:0]          fmt,
  input  logic                fixed_fmt,
  input  logic                always_scale,
  input  logic [RATIO_W-1:0]  ratio_h_luma,
  input  logic [RATIO_W-1:0]  ratio_v_luma,
  input  logic [RATIO_W-1:0]  ratio_h_chroma,
  input  logic [RATIO_W-1:0]  ratio_v_chroma,
  output logic [2:0]          mode,
  output logic [OFFSET_W-1:0] offset_y,
  output logic [OFFSET_W-1:0] offset_c
);
  localparam logic [OFFSET_W-1:0] CHROMA_MID = OFFSET_W'(1) << (OFFSET_W-1);

  logic                      rst_q_n;
  logic [RATIO_W-1:0]        ratio_vec [NUM_RATIOS];
  logic [NUM_RATIOS-1:0]     unity;
  scl_mode_e                 mode_sel;
  logic [OFFSET_W-1:0]       off_y_sel, off_c_sel;
  scl_mode_e                 mode_q, mode_d;
  logic [OFFSET_W-1:0]       off_y_q, off_y_d, off_c_q, off_c_d;

  scl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign ratio_vec[IDX_H_LUMA] = ratio_h_luma;
  assign ratio_vec[IDX_V_LUMA] = ratio_v_luma;
  assign ratio_vec[IDX_H_CHRM] = ratio_h_chroma;
  assign ratio_vec[IDX_V_CHRM] = ratio_v_chroma;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_unity
    scl_unity_detect #(.RATIO_W(RATIO_W), .FRAC_W(FRAC_W)) u_det (
      .ratio  (ratio_vec[i]),
      .is_one (unity[i])
    );
  end

  scl_mode_decide #(.OFFSET_W(OFFSET_W), .CHROMA_MID(CHROMA_MID)) u_decide (
    .fmt          (fmt_class_e'(fmt)),
    .fixed_fmt    (fixed_fmt),
    .always_scale (always_scale),
    .unity        (unity),
    .mode_sel     (mode_sel),
    .off_y_sel    (off_y_sel),
    .off_c_sel    (off_c_sel)
  );

  always_comb begin
    mode_d  = mode_q;
    off_y_d = off_y_q;
    off_c_d = off_c_q;
    if (load) begin
      mode_d  = mode_sel;
      off_y_d = off_y_sel;
      off_c_d = off_c_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q  <= MD_SCL_BYPASS;
      off_y_q <= '0;
      off_c_q <= '0;
    end else begin
      mode_q  <= mode_d;
      off_y_q <= off_y_d;
      off_c_q <= off_c_d;
    end
  end

  assign mode     = mode_q;
  assign offset_y = off_y_q;
  assign offset_c = off_c_q;
endmodule

// File: rtl/scl_mode_select_chk.sv
`timescale 1ns/1ps
module scl_mode_select_chk #(
  parameter int RATIO_W  = 32,
  parameter int OFFSET_W = 16
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                load,
  input logic [1:0]          fmt,
  input logic                fixed_fmt,
  input logic                always_scale,
  input logic [2:0]          mode,
  input logic [OFFSET_W-1:0] offset_y,
  input logic [OFFSET_W-1:0] offset_c
);
  localparam logic [OFFSET_W-1:0] MID = OFFSET_W'(1) << (OFFSET_W-1);

  // R10: no load, nothing moves
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load |=> ($stable(mode) && $stable(offset_y) && $stable(offset_c)));

  // R2: fixed-format FP16 forces scaler bypass
  p_fp16_bypass_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load && fixed_fmt && fmt == 2'd3) |=> (mode == 3'd6));

  // R4 / R8: RGB with always-scale is always RGB scaling
  p_rgb_scale_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load && always_scale && fmt == 2'd0) |=> (mode == 3'd1));

  // R9: luma offset never leaves zero
  p_offset_y_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    offset_y == '0);

  // R9: chroma offset tracks the video class of the loaded format
  p_offset_c_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> (offset_c == (($past(fmt) == 2'd1 || $past(fmt) == 2'd2) ? MID : '0)));

  // R1: mode stays a legal code
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode <= 3'd6);
endmodule

bind scl_mode_select scl_mode_select_chk #(.RATIO_W(RATIO_W), .OFFSET_W(OFFSET_W)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .load         (load),
  .fmt          (fmt),
  .fixed_fmt    (fixed_fmt),
  .always_scale (always_scale),
  .mode         (mode),
  .offset_y     (offset_y),
  .offset_c     (offset_c)
);

// File: tb/scl_mode_select_tb.sv
`timescale 1ns/1ps
module scl_mode_select_tb;
  localparam int RW = 32;
  localparam logic [RW-1:0] ONE  = 32'h0008_0000;
  localparam logic [RW-1:0] UP   = 32'h000C_0000;
  localparam logic [RW-1:0] DN   = 32'h0004_0000;
  localparam logic [RW-1:0] ONEP = 32'h0008_0001;
  localparam logic [RW-1:0] ONEM = 32'h0007_FFFF;

  logic clk = 1'b0;
  logic rst_n, load, fixed_fmt, always_scale;
  logic [1:0] fmt;
  logic [RW-1:0] rhl, rvl, rhc, rvc;
  logic [2:0] mode;
  logic [15:0] offset_y, offset_c;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scl_mode_select u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .fmt(fmt), .fixed_fmt(fixed_fmt),
    .always_scale(always_scale), .ratio_h_luma(rhl), .ratio_v_luma(rvl),
    .ratio_h_chroma(rhc), .ratio_v_chroma(rvc),
    .mode(mode), .offset_y(offset_y), .offset_c(offset_c)
  );

  task automatic check(input string req, input logic [2:0] em, input logic [15:0] ec);
    checks++;
    if (mode !== em || offset_y !== 16'h0 || offset_c !== ec) begin
      fails++;
      $display("FAIL %s: mode=%0d offy=%h offc=%h expected mode=%0d offy=0000 offc=%h",
               req, mode, offset_y, offset_c, em, ec);
    end
  endtask

  function automatic logic [15:0] exp_c(input logic [1:0] f);
    return (f == 2'd1 || f == 2'd2) ? 16'h8000 : 16'h0000;
  endfunction

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic apply(input logic [1:0] f, input logic fx, input logic as,
                       input logic [RW-1:0] a, input logic [RW-1:0] b,
                       input logic [RW-1:0] c, input logic [RW-1:0] d);
    @(negedge clk);
    fmt = f; fixed_fmt = fx; always_scale = as;
    rhl = a; rvl = b; rhc = c; rvc = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load = 1'b0; fmt = 2'd1; fixed_fmt = 1'b0; always_scale = 1'b0;
    rhl = UP; rvl = UP; rhc = UP; rvc = UP;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'd6, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 3'd6, 16'h0);
  endtask

  task automatic t_fp16;
    apply(2'd3, 1'b1, 1'b0, ONE, ONE, ONE, ONE);
    check("R2 unity", 3'd6, 16'h0);
    apply(2'd3, 1'b1, 1'b1, UP, DN, UP, DN);
    check("R2 scaled always_scale", 3'd6, 16'h0);
    apply(2'd3, 1'b0, 1'b0, UP, UP, UP, UP);
    check("R4 fp16 no fixed flag", 3'd1, 16'h0);
  endtask

  task automatic t_unity;
    for (int f = 0; f < 3; f++) begin
      apply(f[1:0], 1'b1, 1'b0, ONE, ONE, ONE, ONE);
      check("R3 unity bypass", 3'd0, exp_c(f[1:0]));
    end
    apply(2'd3, 1'b0, 1'b0, ONE, ONE, ONE, ONE);
    check("R3 fp16 unfixed unity", 3'd0, 16'h0);
  endtask

  task automatic t_444;
    apply(2'd0, 1'b0, 1'b0, UP, ONE, ONE, ONE);
    check("R4 rgb", 3'd1, 16'h0);
    apply(2'd1, 1'b1, 1'b0, ONE, ONE, DN, ONE);
    check("R4 video444", 3'd2, 16'h8000);
  endtask

  task automatic t_420;
    apply(2'd2, 1'b0, 1'b0, ONE, ONE, UP, DN);
    check("R5 luma bypass", 3'd4, 16'h8000);
    apply(2'd2, 1'b1, 1'b0, UP, ONE, ONE, ONE);
    check("R6 chroma bypass", 3'd5, 16'h8000);
    apply(2'd2, 1'b0, 1'b0, ONE, UP, ONE, DN);
    check("R7 both scaled", 3'd3, 16'h8000);
    apply(2'd2, 1'b0, 1'b0, DN, DN, UP, UP);
    check("R7 all scaled", 3'd3, 16'h8000);
  endtask

  task automatic t_always;
    apply(2'd0, 1'b0, 1'b1, ONE, ONE, ONE, ONE);
    check("R8 rgb", 3'd1, 16'h0);
    apply(2'd1, 1'b0, 1'b1, ONE, ONE, ONE, ONE);
    check("R8 video444", 3'd2, 16'h8000);
    apply(2'd2, 1'b0, 1'b1, ONE, ONE, ONE, ONE);
    check("R8 420 luma bypass", 3'd4, 16'h8000);
  endtask

  task automatic t_offsets;
    apply(2'd3, 1'b1, 1'b0, UP, UP, UP, UP);
    check("R9 fp16 offsets", 3'd6, 16'h0);
    apply(2'd1, 1'b0, 1'b0, UP, UP, UP, UP);
    check("R9 video offsets", 3'd2, 16'h8000);
  endtask

  task automatic t_hold;
    apply(2'd2, 1'b0, 1'b0, UP, UP, UP, UP);
    check("R10 setup", 3'd3, 16'h8000);
    @(negedge clk);
    fmt = 2'd0; fixed_fmt = 1'b0; always_scale = 1'b0;
    rhl = ONE; rvl = ONE; rhc = ONE; rvc = ONE;
    repeat (3) @(negedge clk);
    check("R10 hold no load", 3'd3, 16'h8000);
    fmt = 2'd3; fixed_fmt = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 hold fp16 no load", 3'd3, 16'h8000);
  endtask

  task automatic t_exact;
    apply(2'd1, 1'b0, 1'b0, ONEP, ONE, ONE, ONE);
    check("R11 one lsb above", 3'd2, 16'h8000);
    apply(2'd2, 1'b0, 1'b0, ONE, ONE, ONE, ONEM);
    check("R11 chroma one lsb below", 3'd4, 16'h8000);
    apply(2'd2, 1'b0, 1'b0, ONE, ONEM, ONE, ONE);
    check("R11 luma one lsb below", 3'd5, 16'h8000);
  endtask

  initial begin
    t_reset;
    t_fp16;
    t_unity;
    t_444;
    t_420;
    t_always;
    t_offsets;
    t_hold;
    t_exact;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule